// File: doc/BRIEF.md
# Odd-Factor Normalizer with Sign Fold

This block prepares a 16-bit unsigned operand for a compact lookup table. It counts the operand's trailing zero bits (the even-power exponent `p`) with four halving stages that test 8, then 4, then 2, then 1 low bits. Each stage shifts the word right when the bits it tests are all zero. The odd factor left after these stages then has its bit 2 treated as a sign. When that bit is set, the odd factor is replaced by its two's complement modulo 2^16, which is still odd and always has bit 2 clear.

Bits 0 and 2 of the folded value carry no information: bit 0 is always 1 and bit 2 is always 0. Bit 15 is not needed by the table. A 13-bit table index is therefore packed from bit 1 and bits 3 to 14. The seven low index bits (bit 1 and bits 3 to 8 of the folded value) address a 128-row table, and the upper six bits select within the row. A zero operand has no odd factor and is flagged separately.

All outputs are registered and reflect the operand sampled at the previous rising clock edge.

Top module: `prenorm_top`

## Requirements
- R1: For a nonzero operand, `tz_count_o` equals the number of trailing zero bits of the operand, a value from 0 to 15.
- R2: For a zero operand, `zero_o` is 1, `tz_count_o` is 16, `index_o` is 0 and `sign_o` is 0. For any nonzero operand, `zero_o` is 0.
- R3: `sign_o` equals bit 2 of the odd factor, where the odd factor is the operand shifted right by its trailing-zero count.
- R4: When `sign_o` is 0, the folded value is the odd factor itself. The index is formed as follows: `index_o[0]` is bit 1 of the folded value, and `index_o[k]` is bit k+2 of the folded value for k = 1 to 12.
- R5: When `sign_o` is 1, the folded value is (65536 − odd factor) mod 65536, and the index is packed from it in the same way as in R4. For example, operand 0x0014 gives `tz_count_o`=2, `sign_o`=1 and `index_o`=0x1FFF.
- R6: Bit 15 of the folded value has no effect on `index_o`. For example, operands 0x0001 and 0x8001 both give `index_o`=0.
- R7: The outputs change only at a rising clock edge and then show the result for the operand present at that edge, so the latency is one cycle.
- R8: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| operand_i | input | 16 | Operand to normalize |
| tz_count_o | output | 5 | Trailing-zero count, 16 for a zero operand |
| sign_o | output | 1 | Bit 2 of the odd factor |
| index_o | output | 13 | Packed table index from the folded odd factor |
| zero_o | output | 1 | Operand was zero |

## Verification
The hardest cases to reach are the ones where the fold and the normalizer act together. Large shift counts leave only a few significant bits, and with the sign set the negation then floods bits 3 to 14 with ones, as in operand 0x0014. The operand 0x8000 and the zero operand both pass through all four halving stages. Directed tasks cover these cases: every power of two, operands with bit 15 varied for the same index, and hand-worked fold values. An exhaustive sweep of all 65536 operands follows, compared against a loop-based model that counts zeros one bit at a time and negates by subtraction.

// File: rtl/prenorm_pkg.sv
package prenorm_pkg;
  localparam int MAXW = 64;
  typedef logic [MAXW-1:0] wide_t;

  // mask with the n low bits set
  function automatic wide_t low_mask(input int n);
    if (n >= MAXW) return '1;
    return (wide_t'(1) << n) - wide_t'(1);
  endfunction

  // true when the n low bits of v are all zero
  function automatic logic low_zero(input wide_t v, input int n);
    return (v & low_mask(n)) == '0;
  endfunction

  // two's complement negation on the wide type; callers truncate
  function automatic wide_t neg_wide(input wide_t v);
    return ~v + wide_t'(1);
  endfunction
endpackage

// File: rtl/prenorm_tz_stage.sv
module prenorm_tz_stage
  import prenorm_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SHIFT = 8
) (
  input  logic [WIDTH-1:0] val_i,
  output logic [WIDTH-1:0] val_o,
  output logic             hit_o
);
  always_comb begin
    hit_o = low_zero(wide_t'(val_i), SHIFT);
    val_o = hit_o ? (val_i >> SHIFT) : val_i;
  end
endmodule

// File: rtl/prenorm_tz.sv
module prenorm_tz #(
  parameter int WIDTH = 16,
  localparam int NSTAGE = $clog2(WIDTH),
  localparam int CNT_W  = NSTAGE + 1
) (
  input  logic [WIDTH-1:0] operand_i,
  output logic [WIDTH-1:0] odd_o,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o
);
  logic [NSTAGE:0][WIDTH-1:0] chain;
  logic [NSTAGE-1:0]          hits;

  assign chain[0] = operand_i;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    localparam int SH = 1 << (NSTAGE - 1 - k);
    prenorm_tz_stage #(.WIDTH(WIDTH), .SHIFT(SH)) u_stage (
      .val_i (chain[k]),
      .val_o (chain[k+1]),
      .hit_o (hits[NSTAGE-1-k])
    );
  end

  always_comb begin
    zero_o  = (operand_i == '0);
    odd_o   = chain[NSTAGE];
    count_o = zero_o ? CNT_W'(WIDTH) : {1'b0, hits};
  end
endmodule

// File: rtl/prenorm_fold.sv
module prenorm_fold
  import prenorm_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int SIGN_POS = 2
) (
  input  logic [WIDTH-1:0] odd_i,
  output logic             sign_o,
  output logic [WIDTH-1:0] folded_o
);
  always_comb begin
    sign_o   = odd_i[SIGN_POS];
    folded_o = sign_o ? WIDTH'(neg_wide(wide_t'(odd_i))) : odd_i;
  end
endmodule

// File: rtl/prenorm_pack.sv
module prenorm_pack #(
  parameter int WIDTH    = 16,
  parameter int SIGN_POS = 2,
  localparam int IDX_W   = WIDTH - 3
) (
  input  logic [WIDTH-1:0] folded_i,
  output logic [IDX_W-1:0] index_o
);
  // keep bits 1 .. WIDTH-2, skipping the sign position
  for (genvar j = 1; j <= WIDTH - 2; j++) begin : g_bit
    if (j < SIGN_POS) begin : g_lo
      assign index_o[j-1] = folded_i[j];
    end else if (j > SIGN_POS) begin : g_hi
      assign index_o[j-2] = folded_i[j];
    end
  end
endmodule

// File: rtl/prenorm_top.sv
module prenorm_top #(
  parameter int WIDTH    = 16,
  parameter int SIGN_POS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [WIDTH-1:0]          operand_i,
  output logic [$clog2(WIDTH):0]    tz_count_o,
  output logic                      sign_o,
  output logic [WIDTH-4:0]          index_o,
  output logic                      zero_o
);
  localparam int CNT_W = $clog2(WIDTH) + 1;
  localparam int IDX_W = WIDTH - 3;

  logic [WIDTH-1:0] odd_w;
  logic [CNT_W-1:0] cnt_w;
  logic             zero_w;
  logic             sign_w;
  logic [WIDTH-1:0] folded_w;
  logic [IDX_W-1:0] index_w;

  prenorm_tz #(.WIDTH(WIDTH)) u_tz (
    .operand_i (operand_i),
    .odd_o     (odd_w),
    .count_o   (cnt_w),
    .zero_o    (zero_w)
  );

  prenorm_fold #(.WIDTH(WIDTH), .SIGN_POS(SIGN_POS)) u_fold (
    .odd_i    (odd_w),
    .sign_o   (sign_w),
    .folded_o (folded_w)
  );

  prenorm_pack #(.WIDTH(WIDTH), .SIGN_POS(SIGN_POS)) u_pack (
    .folded_i (folded_w),
    .index_o  (index_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tz_count_o <= '0;
      sign_o     <= 1'b0;
      index_o    <= '0;
      zero_o     <= 1'b0;
    end else begin
      tz_count_o <= cnt_w;
      sign_o     <= sign_w;
      index_o    <= index_w;
      zero_o     <= zero_w;
    end
  end

  // normalizer: odd factor shifted back by the count rebuilds the operand
  AST_ODD_REBUILDS: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_w |-> (odd_w[0] && (WIDTH'(odd_w << cnt_w) == operand_i))); // R1
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w <= CNT_W'(WIDTH)); // R1
  AST_ZERO_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |-> (tz_count_o == CNT_W'(WIDTH) && index_o == '0 && !sign_o)); // R2
  // fold: result stays odd and the sign position is always cleared
  AST_FOLD_CLEARS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_w |-> (folded_w[0] && !folded_w[SIGN_POS])); // R5
  AST_FOLD_KEEPS_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    !sign_w |-> (folded_w == odd_w)); // R4
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (zero_o == ($past(operand_i) == '0))); // R7
endmodule

// File: tb/prenorm_top_bench.sv
`timescale 1ns/1ps
module prenorm_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] operand = '0;
  logic [4:0]  tz_count;
  logic        sign;
  logic [12:0] index;
  logic        zero;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  prenorm_top u_prenorm_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .operand_i  (operand),
    .tz_count_o (tz_count),
    .sign_o     (sign),
    .index_o    (index),
    .zero_o     (zero)
  );

  // {count, sign, index, zero}; counts zeros bit by bit, negates by subtraction
  function automatic logic [19:0] model(input logic [15:0] x);
    int p;
    logic [15:0] o, f;
    logic [12:0] ix;
    if (x == 16'd0) return {5'd16, 1'b0, 13'd0, 1'b1};
    p = 0;
    o = x;
    while (o[0] == 1'b0) begin
      o = o >> 1;
      p++;
    end
    f = o[2] ? (16'd0 - o) : o;
    ix[0] = f[1];
    for (int k = 3; k <= 14; k++) ix[k-2] = f[k];
    return {p[4:0], o[2], ix, 1'b0};
  endfunction

  task automatic check(input string req, input logic [19:0] exp);
    logic [19:0] got;
    got = {tz_count, sign, index, zero};
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s op=%h got cnt=%0d sgn=%b idx=%h z=%b exp cnt=%0d sgn=%b idx=%h z=%b",
               req, operand, got[19:15], got[14], got[13:1], got[0],
               exp[19:15], exp[14], exp[13:1], exp[0]);
    end
  endtask

  task automatic apply(input logic [15:0] x, input string req);
    @(negedge clk) operand = x;
    @(negedge clk) check(req, model(x));
  endtask

  task automatic t_reset;
    @(negedge clk) operand = 16'h0014;
    @(negedge clk) check("R8 reset", 20'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_zero;
    apply(16'h0000, "R2 zero");
    check("R2 zero literal", {5'd16, 1'b0, 13'd0, 1'b1});
  endtask

  task automatic t_powers;
    for (int i = 0; i < 16; i++) begin
      apply(16'h0001 << i, "R1 power of two");
      if (tz_count !== i[4:0]) begin
        n_fail++;
        $display("FAIL R1 count got %0d exp %0d", tz_count, i);
      end
      n_checks++;
    end
  endtask

  task automatic t_fold;
    apply(16'h0014, "R5 fold");
    check("R5 fold literal", {5'd2, 1'b1, 13'h1FFF, 1'b0});
    apply(16'h0003, "R4 no fold");
    check("R4 no fold literal", {5'd0, 1'b0, 13'h0001, 1'b0});
    apply(16'hFFFF, "R5 all ones");
    apply(16'h7FF8, "R3 sign on shifted");
  endtask

  task automatic t_bit15;
    apply(16'h0001, "R6 base");
    check("R6 base literal", {5'd0, 1'b0, 13'd0, 1'b0});
    apply(16'h8001, "R6 top bit");
    check("R6 top bit literal", {5'd0, 1'b0, 13'd0, 1'b0});
  endtask

  task automatic t_latency;
    apply(16'h0000, "R7 first");
    @(negedge clk) operand = 16'h0006;
    #5 check("R7 hold before edge", model(16'h0000));
    @(negedge clk) check("R7 after edge", model(16'h0006));
  endtask

  task automatic t_sweep;
    for (int v = 0; v < 65536; v++) begin
      @(negedge clk) begin
        if (v > 0) check("R1 R3 R4 R5 sweep", model(operand));
        operand = v[15:0];
      end
    end
    @(negedge clk) check("R1 R3 R4 R5 sweep", model(operand));
  endtask

  initial begin
    t_reset();
    t_zero();
    t_powers();
    t_fold();
    t_bit15();
    t_latency();
    t_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20ns * 190000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule